// File: doc/BRIEF.md
# Fuse Shadow Cache Loader

This block fills a bank of read-only shadow words from a one-time-programmable fuse array. The array is reached through a single combinational row port. The copy is a fixed schedule. First the test-bit row (row 0) of arrays 0, 2 and 3 is read and judged. Then the selected rows of array 0 follow one row per clock: identity words, IP-disable, user words, user control, ROM-reserved, helper data, security control, secondary key ID and the two public-key hashes. Each row lands in its own shadow word. A status byte reports the test-bit results, a busy flag and a done flag.

A load starts by itself when reset is released. A later load starts when software writes the load command with bit 0 set. Consumers read the shadow words through an index port that has no write path. The words keep their values until the next load.

Top module: `fuse_shadow_loader`

## Requirements
- R1: While reset is high, status reads 0x10 (busy set, done clear). On the first clock edge after reset falls, the automatic load copies schedule step 0. The load completes 45 clocks after reset falls.
- R2: When the block is idle, a command write (`load_wr` high) with `load_wdata[0]`=1 sets busy and clears done on the next clock edge. A command write with bit 0 = 0 leaves status unchanged.
- R3: Busy (status bit 4) stays high for exactly 45 clock edges, one fuse row per edge. On the edge that copies the last row, busy falls and done (status bit 5) rises. Done and busy are never both set. Status bits 3, 6 and 7 always read 0.
- R4: A load command that arrives while busy is high is dropped. This includes a command arriving in the final copy cycle. The load ends at its original time and no second load follows.
- R5: Shadow index 16 holds array-0 row 22 bit for bit. Bit 0 is the key read lock, bit 1 the key write lock, bits 25:11 the signing-enable field, bits 28:27 and 31:30 the two key-invalid fields.
- R6: Shadow indices 0–2 hold array-0 rows 3–5. Index 3 holds row 6. Indices 4–11 hold rows 8–15.
- R7: Index 12 holds row 16 with bits 31:17 forced to 0. Index 13 holds row 17. Indices 14 and 15 hold rows 20 and 21.
- R8: Index 17 holds row 23. Indices 18–29 hold rows 40–51. Indices 30–41 hold rows 52–63.
- R9: Status bits 0, 1 and 2 are set when bits 31:28 of row 0 of array 0, 2 and 3 respectively equal the parameter `TBIT_PATTERN`. Otherwise the bit is clear.
- R10: Indices 42–63 read 0. A change of fuse contents without a load leaves every shadow word unchanged.
- R11: During a load the fuse port addresses these rows in order: array 0 row 0, array 2 row 0, array 3 row 0, then array-0 rows in shadow-index order. Array 1 is never addressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_wr | input | 1 | Write strobe of the load command |
| load_wdata | input | 32 | Load command data; bit 0 requests a load |
| fuse_array | output | 2 | Fuse array select for the row read |
| fuse_row | output | 6 | Fuse row select for the row read |
| fuse_rdata | input | 32 | Row data returned combinationally by the fuse array |
| rd_index | input | 6 | Shadow word index to read |
| rd_data | output | 32 | Shadow word at `rd_index`, 0 for unused indices |
| status | output | 8 | {2'b0, done, busy, 1'b0, tbit3, tbit2, tbit0} |

## Verification
Two things can fall on the same clock edge: a new load command and the capture of the final fuse row, which ends busy. The bench provokes this by holding the command high during the last copy cycle of some loads. It also sends a command in the middle of every load. In both cases it judges the outcome from status: done must rise on the original edge, busy must stay low afterwards, and the shadow words must match the fuse image of that load.

// File: rtl/fsl_pkg.sv
package fsl_pkg;

    localparam int FUSE_W      = 32;
    localparam int ROW_W       = 6;
    localparam int ARR_W       = 2;
    localparam int IDX_W       = 6;
    localparam int NUM_TBITS   = 3;
    localparam int NUM_WORDS   = 42;
    localparam int NUM_STEPS   = NUM_WORDS + NUM_TBITS;
    localparam int STEP_W      = $clog2(NUM_STEPS);
    localparam int MISC_IDX    = 12;
    localparam int MISC_KEEP_W = 17;
    localparam int TBIT_W      = 4;

    typedef struct packed {
        logic [ARR_W-1:0] arr;
        logic [ROW_W-1:0] row;
    } fuse_addr_t;

    typedef enum logic {
        LD_IDLE = 1'b0,
        LD_RUN  = 1'b1
    } ld_state_e;

    // array-0 row that feeds a given shadow index
    function automatic logic [ROW_W-1:0] word_row(input int w);
        int r;
        if (w < 3)       r = 3 + w;
        else if (w == 3) r = 6;
        else if (w < 12) r = 8 + (w - 4);
        else if (w < 14) r = 16 + (w - 12);
        else if (w < 18) r = 20 + (w - 14);
        else             r = 40 + (w - 18);
        return ROW_W'(r);
    endfunction

    // fuse address read at each schedule step
    function automatic fuse_addr_t step_addr(input logic [STEP_W-1:0] s);
        fuse_addr_t a;
        case (s)
            STEP_W'(0): a = '{arr: ARR_W'(0), row: '0};
            STEP_W'(1): a = '{arr: ARR_W'(2), row: '0};
            STEP_W'(2): a = '{arr: ARR_W'(3), row: '0};
            default:    a = '{arr: ARR_W'(0), row: word_row(int'(s) - NUM_TBITS)};
        endcase
        return a;
    endfunction

endpackage

// File: rtl/fsl_sequencer.sv
module fsl_sequencer
    import fsl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    output logic              busy,
    output logic              done,
    output logic [STEP_W-1:0] step
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    ld_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LD_RUN;
            step  <= '0;
            done  <= 1'b0;
        end else begin
            case (state)
                LD_IDLE: begin
                    if (start_req) begin
                        state <= LD_RUN;
                        step  <= '0;
                        done  <= 1'b0;
                    end
                end
                default: begin
                    if (step == LAST_STEP) begin
                        state <= LD_IDLE;
                        done  <= 1'b1;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy = (state == LD_RUN);

endmodule

// File: rtl/fsl_tbit_eval.sv
module fsl_tbit_eval
    import fsl_pkg::*;
#(
    parameter logic [TBIT_W-1:0] PATTERN = 4'hA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [1:0]        slot,
    input  logic [TBIT_W-1:0] top_bits,
    output logic [NUM_TBITS-1:0] pass
);
    for (genvar i = 0; i < NUM_TBITS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                pass[i] <= 1'b0;
            else if (cap_en && slot == 2'(i))
                pass[i] <= (top_bits == PATTERN);
        end
    end

endmodule

// File: rtl/fsl_shadow_bank.sv
module fsl_shadow_bank
    import fsl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [STEP_W-1:0] cap_idx,
    input  logic [FUSE_W-1:0] row_data,
    input  logic [IDX_W-1:0]  rd_index,
    output logic [FUSE_W-1:0] rd_data
);
    localparam logic [FUSE_W-1:0] MISC_MASK = FUSE_W'((64'd1 << MISC_KEEP_W) - 64'd1);

    logic [FUSE_W-1:0] shadow [NUM_WORDS];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        localparam logic [FUSE_W-1:0] KEEP = (w == MISC_IDX) ? MISC_MASK : '1;
        always_ff @(posedge clk) begin
            if (rst)
                shadow[w] <= '0;
            else if (cap_en && cap_idx == STEP_W'(w))
                shadow[w] <= row_data & KEEP;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (rd_index == IDX_W'(w))
                rd_data = shadow[w];
        end
    end

endmodule

// File: rtl/fuse_shadow_loader.sv
module fuse_shadow_loader
    import fsl_pkg::*;
#(
    parameter logic [3:0] TBIT_PATTERN = 4'hA
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load_wr,
    input  logic [31:0] load_wdata,
    output logic [1:0]  fuse_array,
    output logic [5:0]  fuse_row,
    input  logic [31:0] fuse_rdata,
    input  logic [5:0]  rd_index,
    output logic [31:0] rd_data,
    output logic [7:0]  status
);
    logic              busy;
    logic              done;
    logic [STEP_W-1:0] step;
    fuse_addr_t        addr;
    logic              tbit_step;
    logic [NUM_TBITS-1:0] tbit_pass;
    logic              unused_wdata;

    assign unused_wdata = ^load_wdata[31:1];

    fsl_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_req (load_wr & load_wdata[0]),
        .busy      (busy),
        .done      (done),
        .step      (step)
    );

    assign addr       = step_addr(step);
    assign fuse_array = addr.arr;
    assign fuse_row   = addr.row;
    assign tbit_step  = (step < STEP_W'(NUM_TBITS));

    fsl_tbit_eval #(.PATTERN(TBIT_PATTERN)) u_tbit (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (busy & tbit_step),
        .slot     (step[1:0]),
        .top_bits (fuse_rdata[FUSE_W-1 -: TBIT_W]),
        .pass     (tbit_pass)
    );

    fsl_shadow_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (busy & ~tbit_step),
        .cap_idx  (step - STEP_W'(NUM_TBITS)),
        .row_data (fuse_rdata),
        .rd_index (rd_index),
        .rd_data  (rd_data)
    );

    assign status = {2'b00, done, busy, 1'b0, tbit_pass};

endmodule

// File: rtl/fsl_checker.sv
module fsl_checker (
    input logic       clk,
    input logic       rst,
    input logic       load_wr,
    input logic       load_bit0,
    input logic [1:0] fuse_array,
    input logic [5:0] fuse_row,
    input logic [7:0] status
);
    logic busy;
    logic last_row;
    logic go;

    assign busy     = status[4];
    assign last_row = (fuse_array == 2'd0) && (fuse_row == 6'd63);
    assign go       = load_wr && load_bit0;

    AST_DONE_BUSY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(status[4] && status[5]));                                             // R3
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        status[3] == 1'b0 && status[7:6] == 2'b00);                             // R3
    AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (rst)
        busy && !last_row |=> busy);                                            // R3
    AST_FINISH_ONCE: assert property (@(posedge clk) disable iff (rst)
        busy && last_row |=> !status[4] && status[5]);                          // R4
    AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy && go |=> status[4] && !status[5]);                               // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !busy && !go |=> $stable(status));                                      // R2
    AST_NO_ARRAY1: assert property (@(posedge clk) disable iff (rst)
        busy |-> fuse_array != 2'd1);                                           // R11
    AST_ROW_ASCEND: assert property (@(posedge clk) disable iff (rst)
        busy && fuse_array == 2'd0 && fuse_row != 6'd0 && !last_row
        |=> fuse_array == 2'd0 && fuse_row > $past(fuse_row));                  // R11

endmodule

bind fuse_shadow_loader fsl_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_wr    (load_wr),
    .load_bit0  (load_wdata[0]),
    .fuse_array (fuse_array),
    .fuse_row   (fuse_row),
    .status     (status)
);

// File: tb/sim_fuse_shadow_loader.sv
module sim_fuse_shadow_loader;
    localparam time        CLK_PERIOD = 10ns;
    localparam logic [3:0] PAT        = 4'hA;

    logic        clk = 1'b0;
    logic        rst;
    logic        load_wr;
    logic [31:0] load_wdata;
    logic [1:0]  fuse_array;
    logic [5:0]  fuse_row;
    logic [31:0] fuse_rdata;
    logic [5:0]  rd_index;
    logic [31:0] rd_data;
    logic [7:0]  status;

    logic [31:0] fmem [0:3][0:63];
    logic [31:0] snap [0:41];
    logic [2:0]  exp_tb;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb fuse_rdata = fmem[fuse_array][fuse_row];

    fuse_shadow_loader #(.TBIT_PATTERN(PAT)) u0 (
        .clk(clk), .rst(rst), .load_wr(load_wr), .load_wdata(load_wdata),
        .fuse_array(fuse_array), .fuse_row(fuse_row), .fuse_rdata(fuse_rdata),
        .rd_index(rd_index), .rd_data(rd_data), .status(status)
    );

    function automatic int exp_row(input int idx);
        if (idx <= 2)  return idx + 3;
        if (idx == 3)  return 6;
        if (idx <= 11) return idx + 4;
        if (idx <= 13) return idx + 4;
        if (idx <= 17) return idx + 6;
        return idx + 22;
    endfunction

    function automatic logic [31:0] exp_word(input int idx);
        logic [31:0] v;
        v = fmem[0][exp_row(idx)];
        if (idx == 12) v = {15'd0, v[16:0]};
        return v;
    endfunction

    function automatic string req_of(input int idx);
        if (idx == 16) return "R5";
        if (idx <= 11) return "R6";
        if (idx <= 15) return "R7";
        return "R8";
    endfunction

    function automatic logic [7:0] exp_status(input logic busy, input logic done);
        return {2'b00, done, busy, 1'b0, exp_tb};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill_fuses(input logic [2:0] tb);
        for (int a = 0; a < 4; a++)
            for (int r = 0; r < 64; r++)
                fmem[a][r] = $urandom;
        fmem[0][0][31:28] = tb[0] ? PAT : PAT ^ 4'h5;
        fmem[2][0][31:28] = tb[1] ? PAT : PAT ^ 4'h5;
        fmem[3][0][31:28] = tb[2] ? PAT : PAT ^ 4'h5;
        exp_tb = tb;
        for (int w = 0; w < 42; w++) snap[w] = exp_word(w);
    endtask

    task automatic check_words();
        for (int w = 0; w < 42; w++) begin
            rd_index = 6'(w);
            #1;
            check(req_of(w), rd_data, snap[w]);
        end
    endtask

    initial begin
        void'($urandom(32'd777));
        rst = 1'b1; load_wr = 1'b0; load_wdata = '0; rd_index = '0;
        fill_fuses(3'b101);
        repeat (3) @(negedge clk);
        check("R1", {24'd0, status}, 32'h10);
        rst = 1'b0;
        #1;
        // automatic load: address walk and timing
        for (int k = 0; k < 45; k++) begin
            logic [7:0] ea;
            if (k == 0)      ea = {2'd0, 6'd0};
            else if (k == 1) ea = {2'd2, 6'd0};
            else if (k == 2) ea = {2'd3, 6'd0};
            else             ea = {2'd0, 6'(exp_row(k - 3))};
            check("R11", {24'd0, fuse_array, fuse_row}, {24'd0, ea});
            check("R1", {31'd0, status[4]}, 32'd1);
            @(negedge clk);
            #1;
        end
        check("R1", {24'd0, status}, {24'd0, exp_status(1'b0, 1'b1)});
        check("R9", {29'd0, status[2:0]}, {29'd0, exp_tb});
        check_words();

        // unused indices and persistence
        rd_index = 6'd42; #1; check("R10", rd_data, 32'd0);
        rd_index = 6'd63; #1; check("R10", rd_data, 32'd0);
        for (int r = 0; r < 64; r++) fmem[0][r] = ~fmem[0][r];
        repeat (2) @(negedge clk);
        check_words();

        // command without bit 0
        load_wr = 1'b1; load_wdata = 32'hFFFF_FFFE;
        @(negedge clk);
        load_wr = 1'b0;
        check("R2", {24'd0, status}, {24'd0, exp_status(1'b0, 1'b1)});
        @(negedge clk);
        check("R2", {24'd0, status}, {24'd0, exp_status(1'b0, 1'b1)});

        for (int rnd = 0; rnd < 5; rnd++) begin
            fill_fuses(3'($urandom));
            load_wr = 1'b1; load_wdata = {$urandom, 1'b1} >> 0 | 32'd1;
            @(negedge clk);
            load_wr = 1'b0;
            check("R2", {24'd0, status[7:3], 3'd0}, {24'd0, 8'h10});
            for (int k = 2; k <= 45; k++) begin
                @(negedge clk);
                load_wr    = (k == 10) || ((rnd % 2 == 1) && k == 45);
                load_wdata = 32'd1;
            end
            check("R3", {31'd0, status[4]}, 32'd1);
            @(negedge clk);
            load_wr = 1'b0;
            check("R4", {24'd0, status}, {24'd0, exp_status(1'b0, 1'b1)});
            @(negedge clk);
            check("R4", {24'd0, status}, {24'd0, exp_status(1'b0, 1'b1)});
            check("R9", {29'd0, status[2:0]}, {29'd0, exp_tb});
            check_words();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule